// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block forms the second operand of an integer ALU. It is purely combinational. In register mode it shifts a 32-bit source value left or right, either logically or arithmetically, or rotates it. The amount comes from a 5-bit instruction field or from the low byte of a second register. In immediate mode it ignores the source value and produces an 8-bit constant, zero-extended and rotated right by twice a 4-bit rotate field.

Along with the value, the block gives the carry that the shift produces and an enable that tells the flag register whether to take it. When flags are requested, the enable is raised in every case except a register-mode logical left shift by zero. In that case the stored carry keeps its old value. The surrounding datapath owns the arithmetic, the flag storage and the decode. It feeds the current carry flag in on `carry_in` so that zero-distance cases can pass it through.

Top module: `operand_shifter`

## Requirements
- R1: In register mode, `shift_kind` selects the operation: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. For an amount n from 1 to 31, `carry_out` is the last bit moved out: source bit 32-n for a left shift, and source bit n-1 for the other three.
- R2: When `amt_from_reg` is 1 the amount is `amt_src[7:0]`, and bits 31:8 of `amt_src` have no effect. When it is 0 the amount is `amt_field`.
- R3: In register mode with an amount of zero, `op_out` equals `src_val` and `carry_out` equals `carry_in`, whatever the shift kind.
- R4: In register mode, `carry_we` equals `flags_req`, except for a logical left shift by zero, where `carry_we` is 0.
- R5: A logical shift by exactly 32 gives `op_out` of zero. Its carry is source bit 0 for a left shift and source bit 31 for a right shift. A logical shift by 33 or more gives zero with a carry of 0.
- R6: An arithmetic right shift by 32 or more fills all 32 bits with source bit 31, and `carry_out` is also source bit 31.
- R7: A rotate uses the amount modulo 32. A nonzero amount that is a multiple of 32 leaves the value unchanged and gives source bit 31 as `carry_out`.
- R8: In immediate mode, `op_out` is `{24'b0, imm_byte}` rotated right by 2×`imm_rot`. `src_val`, `shift_kind` and both amount inputs have no effect.
- R9: In immediate mode, `carry_we` equals `flags_req`. `carry_out` is bit 31 of the rotated value when `imm_rot` is nonzero, and equals `carry_in` when it is zero.
- R10: When `flags_req` is 0, `carry_we` is 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| imm_mode | input | 1 | 1 selects the rotated-constant path; 0 selects the register shift |
| src_val | input | 32 | Value to shift in register mode |
| amt_src | input | 32 | Register holding a shift amount; only bits 7:0 are used |
| amt_from_reg | input | 1 | 1 takes the amount from `amt_src`, 0 from `amt_field` |
| amt_field | input | 5 | Shift amount from the instruction field |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| imm_byte | input | 8 | 8-bit constant for immediate mode |
| imm_rot | input | 4 | Rotate field; the rotation is twice this value |
| flags_req | input | 1 | The instruction asks for flag update |
| carry_in | input | 1 | Current carry flag |
| op_out | output | 32 | Shifted or rotated operand |
| carry_out | output | 1 | Shifter carry |
| carry_we | output | 1 | Write enable for the carry flag |

## Verification
The assertions take it for granted that all inputs are at known 0/1 levels whenever outputs are compared. They are evaluated on each settled combinational change, so no input may change in the middle of a compare. The stimulus changes every input together inside one task call. It then waits a fixed delay before reading the outputs, and it never leaves any input undriven. Register amounts are chosen to land on each region that changes behaviour: 0, 1 to 31, exactly 32, 33 and far beyond. Nonzero upper bits are also driven in `amt_src` to show that they are ignored.

// File: rtl/operand_shifter.sv
module operand_shifter (
  input  logic        imm_mode,
  input  logic [31:0] src_val,
  input  logic [31:0] amt_src,
  input  logic        amt_from_reg,
  input  logic [4:0]  amt_field,
  input  logic [1:0]  shift_kind,
  input  logic [7:0]  imm_byte,
  input  logic [3:0]  imm_rot,
  input  logic        flags_req,
  input  logic        carry_in,
  output logic [31:0] op_out,
  output logic        carry_out,
  output logic        carry_we
);

  function automatic logic [31:0] rotr(input logic [31:0] v, input logic [4:0] k);
    rotr = (v >> k) | (v << (6'd32 - {1'b0, k}));
  endfunction

  logic [7:0]         amt8;
  logic [5:0]         amt_sat;
  logic [32:0]        lsl_w, lsr_w;
  logic signed [32:0] asr_w;
  logic [31:0]        ror_v, imm_v;
  logic [4:0]         imm_k;

  assign amt8    = amt_from_reg ? amt_src[7:0] : {3'b000, amt_field};
  assign amt_sat = (amt8 > 8'd33) ? 6'd33 : amt8[5:0];
  assign lsl_w   = {1'b0, src_val} << amt_sat;
  assign lsr_w   = {src_val, 1'b0} >> amt_sat;
  assign asr_w   = $signed({src_val, 1'b0}) >>> amt_sat;
  assign ror_v   = rotr(src_val, amt8[4:0]);
  assign imm_k   = {imm_rot, 1'b0};
  assign imm_v   = rotr({24'd0, imm_byte}, imm_k);

  always_comb begin
    if (imm_mode) begin
      op_out    = imm_v;
      carry_out = (imm_rot == 4'd0) ? carry_in : imm_v[31];
    end else if (amt8 == 8'd0) begin
      op_out    = src_val;
      carry_out = carry_in;
    end else begin
      unique case (shift_kind)
        2'd0:    begin op_out = lsl_w[31:0];  carry_out = lsl_w[32]; end
        2'd1:    begin op_out = lsr_w[32:1];  carry_out = lsr_w[0];  end
        2'd2:    begin op_out = asr_w[32:1];  carry_out = asr_w[0];  end
        default: begin op_out = ror_v;        carry_out = ror_v[31]; end
      endcase
    end
  end

  assign carry_we = flags_req & (imm_mode | (shift_kind != 2'd0) | (amt8 != 8'd0));

endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk (
  input logic        imm_mode,
  input logic [31:0] src_val,
  input logic [31:0] amt_src,
  input logic        amt_from_reg,
  input logic [4:0]  amt_field,
  input logic [1:0]  shift_kind,
  input logic [7:0]  imm_byte,
  input logic [3:0]  imm_rot,
  input logic        flags_req,
  input logic        carry_in,
  input logic [31:0] op_out,
  input logic        carry_out,
  input logic        carry_we
);
  logic [7:0] amt_seen;
  assign amt_seen = amt_from_reg ? amt_src[7:0] : {3'b000, amt_field};

  always_comb begin
    p_no_stray_write_r10: assert (flags_req || !carry_we)
      else $error("carry_we without flags_req");
    if (imm_mode) begin
      p_imm_write_r9: assert (carry_we == flags_req)
        else $error("immediate mode carry_we mismatch");
      p_imm_bits_r8: assert ($countones(op_out) == $countones(imm_byte))
        else $error("rotated constant lost bits");
    end else begin
      if (amt_seen == 8'd0) begin
        p_zero_pass_r3: assert (op_out == src_val && carry_out == carry_in)
          else $error("zero amount altered value or carry");
        if (shift_kind == 2'd0) begin
          p_lsl0_hold_r4: assert (!carry_we)
            else $error("LSL #0 requested a carry write");
        end
      end
      if (shift_kind == 2'd3) begin
        p_ror_bits_r7: assert ($countones(op_out) == $countones(src_val))
          else $error("rotation changed bit count");
      end
      if (shift_kind == 2'd2 && amt_seen >= 8'd32) begin
        p_asr_fill_r6: assert ($countones(op_out) == 0 || $countones(op_out) == 32)
          else $error("wide ASR not uniform");
      end
      if (shift_kind == 2'd1 && amt_seen >= 8'd32) begin
        p_lsr_clear_r5: assert (op_out == 32'd0)
          else $error("wide LSR not zero");
      end
    end
  end
endmodule

bind operand_shifter operand_shifter_chk u_chk (.*);

// File: tb/operand_shifter_tb.sv
module operand_shifter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        imm_mode, amt_from_reg, flags_req, carry_in;
  logic [31:0] src_val, amt_src;
  logic [4:0]  amt_field;
  logic [1:0]  shift_kind;
  logic [7:0]  imm_byte;
  logic [3:0]  imm_rot;
  logic [31:0] op_out;
  logic        carry_out, carry_we;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  int wd    = 0;

  operand_shifter u_dut (
    .imm_mode(imm_mode), .src_val(src_val), .amt_src(amt_src),
    .amt_from_reg(amt_from_reg), .amt_field(amt_field), .shift_kind(shift_kind),
    .imm_byte(imm_byte), .imm_rot(imm_rot), .flags_req(flags_req),
    .carry_in(carry_in), .op_out(op_out), .carry_out(carry_out), .carry_we(carry_we)
  );

  always @(posedge clk) begin
    if (!rst_n) wd <= 0;
    else if (!done) begin
      wd <= wd + 1;
      if (wd > 100000) begin
        n_vec++; n_bad++;
        $display("FAIL watchdog: run hung, actual=%0d expected<=100000 cycles", wd);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  // Step-by-step reference: move one bit per step and record what falls out.
  task automatic expect_vals(output logic [31:0] ev, output logic ec, output logic ew);
    logic [31:0] v;
    logic c;
    int n;
    if (imm_mode) begin
      v = {24'd0, imm_byte};
      c = carry_in;
      for (int i = 0; i < 2 * imm_rot; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
      ew = flags_req;
    end else begin
      n = amt_from_reg ? int'(amt_src[7:0]) : int'(amt_field);
      v = src_val;
      c = carry_in;
      case (shift_kind)
        2'd0: for (int i = 0; i < n; i++) begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'd1: for (int i = 0; i < n; i++) begin c = v[0]; v = {1'b0, v[31:1]}; end
        2'd2: for (int i = 0; i < n; i++) begin c = v[0]; v = {v[31], v[31:1]}; end
        default: begin
          for (int i = 0; i < n % 32; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
          if (n != 0 && n % 32 == 0) c = v[31];
        end
      endcase
      ew = flags_req && !(shift_kind == 2'd0 && n == 0);
    end
    ev = v;
    ec = c;
  endtask

  task automatic check(input string req);
    logic [31:0] ev;
    logic ec, ew;
    #2;
    expect_vals(ev, ec, ew);
    n_vec++;
    if (op_out !== ev || carry_out !== ec || carry_we !== ew) begin
      n_bad++;
      $display("FAIL %s: actual val=%h c=%b we=%b expected val=%h c=%b we=%b",
               req, op_out, carry_out, carry_we, ev, ec, ew);
    end
    #1;
  endtask

  task automatic drive_reg(input logic [31:0] s, input logic [1:0] k, input logic from_reg,
                           input logic [31:0] ra, input logic [4:0] fa,
                           input logic fl, input logic ci);
    imm_mode = 1'b0; src_val = s; shift_kind = k; amt_from_reg = from_reg;
    amt_src = ra; amt_field = fa; flags_req = fl; carry_in = ci;
    imm_byte = 8'hA5; imm_rot = 4'h7;
  endtask

  task automatic drive_imm(input logic [7:0] b, input logic [3:0] r, input logic fl,
                           input logic ci, input logic [31:0] junk);
    imm_mode = 1'b1; imm_byte = b; imm_rot = r; flags_req = fl; carry_in = ci;
    src_val = junk; amt_src = ~junk; amt_field = junk[4:0]; shift_kind = junk[6:5];
    amt_from_reg = junk[7];
  endtask

  task automatic t_reset_state;
    drive_reg(32'd0, 2'd0, 1'b0, 32'd0, 5'd0, 1'b0, 1'b0);
    check("R3 idle");
  endtask

  task automatic t_types;   // R1
    logic [31:0] pats [3] = '{32'h8000_0001, 32'h7F3C_9A55, 32'hC000_0003};
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 4; k++)
        foreach (pats[i]) if (i == p) begin
          drive_reg(pats[i], 2'(k), 1'b0, 32'd0, 5'd1, 1'b1, 1'b0); check("R1 n=1");
          drive_reg(pats[i], 2'(k), 1'b0, 32'd0, 5'd13, 1'b1, 1'b1); check("R1 n=13");
          drive_reg(pats[i], 2'(k), 1'b0, 32'd0, 5'd31, 1'b1, 1'b0); check("R1 n=31");
        end
  endtask

  task automatic t_amt_src; // R2
    drive_reg(32'h1234_5678, 2'd1, 1'b1, 32'hFFFF_FF04, 5'd20, 1'b1, 1'b0); check("R2 low byte");
    drive_reg(32'h1234_5678, 2'd0, 1'b1, 32'h0000_0008, 5'd1, 1'b1, 1'b0); check("R2 reg amt");
    drive_reg(32'h1234_5678, 2'd0, 1'b0, 32'h0000_0008, 5'd3, 1'b1, 1'b0); check("R2 field amt");
    drive_reg(32'h1234_5678, 2'd3, 1'b1, 32'h7654_3200, 5'd9, 1'b1, 1'b1); check("R2 upper ignored");
  endtask

  task automatic t_zero;    // R3, R4
    for (int k = 0; k < 4; k++) begin
      drive_reg(32'hDEAD_BEEF, 2'(k), 1'b0, 32'd0, 5'd0, 1'b1, 1'b1); check("R3/R4 zero field");
      drive_reg(32'hDEAD_BEEF, 2'(k), 1'b1, 32'hABCD_0000, 5'd7, 1'b1, 1'b0); check("R3/R4 zero reg");
    end
  endtask

  task automatic t_logical_wide; // R5
    drive_reg(32'h0000_0001, 2'd0, 1'b1, 32'd32, 5'd0, 1'b1, 1'b0); check("R5 LSL32");
    drive_reg(32'h8000_0000, 2'd1, 1'b1, 32'd32, 5'd0, 1'b1, 1'b0); check("R5 LSR32");
    drive_reg(32'hFFFF_FFFF, 2'd0, 1'b1, 32'd33, 5'd0, 1'b1, 1'b1); check("R5 LSL33");
    drive_reg(32'hFFFF_FFFF, 2'd1, 1'b1, 32'd200, 5'd0, 1'b1, 1'b1); check("R5 LSR200");
  endtask

  task automatic t_asr_wide; // R6
    drive_reg(32'h8000_0010, 2'd2, 1'b1, 32'd32, 5'd0, 1'b1, 1'b0); check("R6 neg 32");
    drive_reg(32'h7FFF_FFFF, 2'd2, 1'b1, 32'd255, 5'd0, 1'b1, 1'b1); check("R6 pos 255");
    drive_reg(32'h9000_0000, 2'd2, 1'b1, 32'd40, 5'd0, 1'b1, 1'b0); check("R6 neg 40");
  endtask

  task automatic t_ror_mod; // R7
    drive_reg(32'h8000_0002, 2'd3, 1'b1, 32'd32, 5'd0, 1'b1, 1'b0); check("R7 ror32");
    drive_reg(32'h0000_0002, 2'd3, 1'b1, 32'd64, 5'd0, 1'b1, 1'b1); check("R7 ror64");
    drive_reg(32'h0000_00F1, 2'd3, 1'b1, 32'd36, 5'd0, 1'b1, 1'b0); check("R7 ror36");
  endtask

  task automatic t_imm;     // R8, R9
    drive_imm(8'hFF, 4'd0, 1'b1, 1'b1, 32'hFFFF_FFFF); check("R8/R9 rot0 cin1");
    drive_imm(8'h81, 4'd0, 1'b1, 1'b0, 32'h1357_9BDF); check("R8/R9 rot0 cin0");
    drive_imm(8'h03, 4'd1, 1'b1, 1'b0, 32'h0F0F_0F0F); check("R8/R9 rot2 carry1");
    drive_imm(8'h3F, 4'd4, 1'b1, 1'b1, 32'hAAAA_5555); check("R8/R9 rot8");
    drive_imm(8'hC0, 4'd15, 1'b1, 1'b0, 32'h0000_00E0); check("R8/R9 rot30");
    drive_imm(8'h01, 4'd1, 1'b1, 1'b0, 32'hFFFF_FFFF); check("R8/R9 bit0 wraps");
  endtask

  task automatic t_noflags; // R10
    drive_reg(32'hF00F_F00F, 2'd1, 1'b0, 32'd0, 5'd5, 1'b0, 1'b1); check("R10 reg");
    drive_reg(32'hF00F_F00F, 2'd3, 1'b1, 32'd0, 5'd0, 1'b0, 1'b0); check("R10 zero amt");
    drive_imm(8'h55, 4'd3, 1'b0, 1'b1, 32'd0); check("R10 imm");
  endtask

  initial begin
    drive_reg(32'd0, 2'd0, 1'b0, 32'd0, 5'd0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_types();
    t_amt_src();
    t_zero();
    t_logical_wide();
    t_asr_wide();
    t_ror_mod();
    t_imm();
    t_noflags();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule